// File: doc/BRIEF.md
# Outer-Product Accumulation Array

This block forms the 3×3 product of a 3×64 matrix and a 64×3 matrix by summing 64 outer products. Each period, two 3-element column vectors arrive together: column `a` (one column of the left matrix) and column `b` (the matching row of the right matrix, taken as a column). The block adds `a·bᵀ` into a grid of nine running sums. A typical use is forming terms such as `tanh(u)·uᵀ` inside an adaptive separation engine. The same array serves any such product: the caller only changes which streams it feeds.

Only three multipliers are used. A captured column pair is processed over a three-cycle period. In phase `k` of the period, the multipliers form `a[k]·b[0]`, `a[k]·b[1]` and `a[k]·b[2]`, and those products are added into row `k` of the grid. A clear pulse starts a new block. After the 64th period completes, a done strobe rises and the nine sums hold still until the next clear.

Top module: `opa_accum_array`

## Requirements
- R1: After a block of 64 accepted columns, result entry (i,j) equals the sum over all columns n of a_n[i]·b_n[j]. That entry sits at bits [(i·3+j)·AW +: AW] of `res_flat`, and element k of a column input sits at bits [k·16 +: 16].
- R2: Operands are 16-bit two's complement. Each accumulator is AW = 2·16 + log2(64) + 1 = 39 bits, signed. The extreme cases (all operands −32768, or −32768 against 32767) give exact sums with no overflow.
- R3: A column pair is taken only on a rising edge where both `col_vld` and `col_rdy` are high. `col_rdy` is high when the array is idle and also in the last cycle of a period, so back-to-back columns can be taken every 3 cycles.
- R4: When columns are fed without gaps, `done` rises exactly 3·64 = 192 rising edges after the edge that took the first column of the block.
- R5: While `done` is high, `col_rdy` is low, `col_vld` is ignored, and `res_flat` does not change until a clear.
- R6: A `clr` pulse zeroes all nine sums, lowers `done` and restarts the column count on the next edge. It takes priority over a `col_vld` presented in the same cycle, and that column is not taken.
- R7: Idle cycles between columns (with `col_vld` low) do not change the final result.
- R8: After reset, `done` is low, `col_rdy` is high and all nine sums are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Start-of-block clear pulse |
| col_vld | input | 1 | Column pair presented |
| col_a | input | 48 | Left column, three 16-bit signed elements |
| col_b | input | 48 | Right column, three 16-bit signed elements |
| col_rdy | output | 1 | Column pair can be taken this cycle |
| done | output | 1 | Block of 64 columns fully accumulated |
| res_flat | output | 351 | Nine 39-bit signed sums, row-major |

## Verification
The bench goes after the following corner cases:

- **Row-to-phase mapping.** Random blocks are compared entry by entry. A design that pairs the wrong `a` element with a phase would put sums in swapped rows.
- **Accumulator width.** Blocks built from the most negative operand push every accumulator to its largest magnitude. A design whose accumulators are too narrow, or that treats operands as unsigned, would return wrapped values.
- **Latency and pipelining.** The count from first take to `done` must be exactly 192. A design that only takes a new column after an idle cycle would stretch this count.
- **Hold after done.** A burst of valid columns is driven while `done` is high. A design that keeps taking columns would change the held sums.
- **Clear behaviour.** A clear is issued in the same cycle as a valid column, and another clear partway through a block. A design that lets the column through, or does not reset its count, would finish early or fold stale data into the new block.

// File: rtl/opa_pkg.sv
package opa_pkg;

   // Width needed to sum blk full-precision dw x dw products, plus one guard bit
   // so that the unsigned variant also fits in a signed container.
   function automatic int acc_width(input int dw, input int blk);
      return 2 * dw + $clog2(blk) + 1;
   endfunction

endpackage

// File: rtl/opa_seq.sv
module opa_seq #(
   parameter int DIM   = 3,
   parameter int BLOCK = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           vld,
   output logic           ready,
   output logic           load,
   output logic           done,
   output logic [DIM-1:0] row_en
);

   localparam int PW = (DIM > 1) ? $clog2(DIM) : 1;
   localparam int CW = $clog2(BLOCK + 1);
   localparam logic [PW-1:0] LAST_PH = PW'(DIM - 1);
   localparam logic [CW-1:0] FULL    = CW'(BLOCK);

   logic          active;
   logic [PW-1:0] phase;
   logic [CW-1:0] col_cnt;
   logic          done_q;
   logic          period_end;

   assign period_end = active && (phase == LAST_PH);
   assign ready      = !done_q && (col_cnt != FULL) && (!active || period_end);
   assign load       = vld && ready && !clr;
   assign done       = done_q;

   always_comb begin
      for (int k = 0; k < DIM; k++)
         row_en[k] = active && (phase == PW'(k));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         phase   <= '0;
         col_cnt <= '0;
         done_q  <= 1'b0;
      end else if (clr) begin
         active  <= 1'b0;
         phase   <= '0;
         col_cnt <= '0;
         done_q  <= 1'b0;
      end else if (load) begin
         active  <= 1'b1;
         phase   <= '0;
         col_cnt <= col_cnt + 1'b1;
      end else if (active) begin
         if (period_end) begin
            active <= 1'b0;
            if (col_cnt == FULL)
               done_q <= 1'b1;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_cnt <= FULL);

   // R3
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !ready && !clr) |=> $stable(col_cnt));

   // R5
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr) |=> done_q);

   // R6
   clr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!done_q && col_cnt == '0 && !active));

endmodule

// File: rtl/opa_mul_row.sv
module opa_mul_row #(
   parameter int DW     = 16,
   parameter int DIM    = 3,
   parameter int AW     = 39,
   parameter bit SIGNED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DIM*DW-1:0] a_vec,
   input  logic [DIM*DW-1:0] b_vec,
   input  logic [DIM-1:0]    row_en,
   output logic [DIM*AW-1:0] prod_flat
);

   logic [DW-1:0] a_r [DIM];
   logic [DW-1:0] b_r [DIM];
   logic [DW-1:0] a_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DIM; k++) begin
            a_r[k] <= '0;
            b_r[k] <= '0;
         end
      end else if (load) begin
         for (int k = 0; k < DIM; k++) begin
            a_r[k] <= a_vec[k*DW +: DW];
            b_r[k] <= b_vec[k*DW +: DW];
         end
      end
   end

   // one-hot select of the a element for the current phase
   always_comb begin
      a_sel = '0;
      for (int k = 0; k < DIM; k++)
         if (row_en[k]) a_sel = a_sel | a_r[k];
   end

   for (genvar j = 0; j < DIM; j++) begin : g_mul
      if (SIGNED) begin : g_s
         logic signed [2*DW-1:0] p;
         assign p = $signed(a_sel) * $signed(b_r[j]);
         assign prod_flat[j*AW +: AW] = {{(AW-2*DW){p[2*DW-1]}}, p};
      end else begin : g_u
         logic [2*DW-1:0] p;
         assign p = a_sel * b_r[j];
         assign prod_flat[j*AW +: AW] = {{(AW-2*DW){1'b0}}, p};
      end
   end

endmodule

// File: rtl/opa_acc_grid.sv
module opa_acc_grid #(
   parameter int DIM = 3,
   parameter int AW  = 39
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic [DIM-1:0]        row_en,
   input  logic [DIM*AW-1:0]     prod_flat,
   output logic [DIM*DIM*AW-1:0] res_flat
);

   for (genvar i = 0; i < DIM; i++) begin : g_row
      for (genvar j = 0; j < DIM; j++) begin : g_col
         logic [AW-1:0] acc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               acc <= '0;
            else if (clr)
               acc <= '0;
            else if (row_en[i])
               acc <= acc + prod_flat[j*AW +: AW];
         end
         assign res_flat[(i*DIM+j)*AW +: AW] = acc;
      end
   end

   // R3
   row_oh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_en));

endmodule

// File: rtl/opa_accum_array.sv
module opa_accum_array #(
   parameter  int DW     = 16,
   parameter  int DIM    = 3,
   parameter  int BLOCK  = 64,
   parameter  bit SIGNED = 1'b1,
   localparam int AW     = opa_pkg::acc_width(DW, BLOCK)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  col_vld,
   input  logic [DIM*DW-1:0]     col_a,
   input  logic [DIM*DW-1:0]     col_b,
   output logic                  col_rdy,
   output logic                  done,
   output logic [DIM*DIM*AW-1:0] res_flat
);

   if (DW < 2) begin : g_bad_dw
      $error("opa_accum_array: DW must be at least 2");
   end
   if (DIM < 1) begin : g_bad_dim
      $error("opa_accum_array: DIM must be at least 1");
   end
   if (BLOCK < 1) begin : g_bad_blk
      $error("opa_accum_array: BLOCK must be at least 1");
   end

   logic           load;
   logic [DIM-1:0] row_en;
   logic [DIM*AW-1:0] prod_flat;

   opa_seq #(.DIM(DIM), .BLOCK(BLOCK)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .vld    (col_vld),
      .ready  (col_rdy),
      .load   (load),
      .done   (done),
      .row_en (row_en)
   );

   opa_mul_row #(.DW(DW), .DIM(DIM), .AW(AW), .SIGNED(SIGNED)) u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .a_vec     (col_a),
      .b_vec     (col_b),
      .row_en    (row_en),
      .prod_flat (prod_flat)
   );

   opa_acc_grid #(.DIM(DIM), .AW(AW)) u_grid (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .row_en    (row_en),
      .prod_flat (prod_flat),
      .res_flat  (res_flat)
   );

   // R5
   res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> $stable(res_flat));

   // R6
   res_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (res_flat == '0 && !done));

endmodule

// File: tb/sim_opa_accum_array.sv
`timescale 1ns/1ps
module sim_opa_accum_array;

   localparam int DW = 16, DIM = 3, BLOCK = 64, AW = 39;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic col_vld = 1'b0;
   logic [DIM*DW-1:0] col_a = '0, col_b = '0;
   logic col_rdy, done;
   logic [DIM*DIM*AW-1:0] res_flat;

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;
   int ta [BLOCK][DIM];
   int tb [BLOCK][DIM];

   always #4 clk = ~clk;
   always @(posedge clk) cyc++;

   opa_accum_array u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .col_vld(col_vld),
      .col_a(col_a), .col_b(col_b), .col_rdy(col_rdy), .done(done),
      .res_flat(res_flat)
   );

   task automatic check(input string req, input string what, input longint got, input longint exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   function automatic longint entry(input int i, input int j);
      logic [AW-1:0] v;
      v = res_flat[(i*DIM+j)*AW +: AW];
      return longint'($signed(v));
   endfunction

   function automatic longint ref_entry(input int i, input int j);
      longint s = 0;
      for (int n = 0; n < BLOCK; n++) s += longint'(ta[n][i]) * longint'(tb[n][j]);
      return s;
   endfunction

   task automatic check_all(input string req);
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++)
            check(req, $sformatf("entry(%0d,%0d)", i, j), entry(i, j), ref_entry(i, j));
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   // feeds the block held in ta/tb; returns edges from first take to done
   task automatic feed_block(input int gap, output int lat);
      int first = 0;
      for (int n = 0; n < BLOCK; n++) begin
         @(negedge clk);
         col_vld = 1'b0;
         while (!col_rdy) @(negedge clk);
         for (int k = 0; k < DIM; k++) begin
            col_a[k*DW +: DW] = 16'(ta[n][k]);
            col_b[k*DW +: DW] = 16'(tb[n][k]);
         end
         col_vld = 1'b1;
         if (n == 0) first = cyc + 1;
         if (gap > 0) begin
            @(negedge clk); col_vld = 1'b0;
            repeat (gap - 1) @(negedge clk);
         end
      end
      @(negedge clk); col_vld = 1'b0;
      while (!done) @(negedge clk);
      lat = cyc - first;
   endtask

   task automatic fill_random();
      for (int n = 0; n < BLOCK; n++)
         for (int k = 0; k < DIM; k++) begin
            ta[n][k] = int'($signed(16'($urandom)));
            tb[n][k] = int'($signed(16'($urandom)));
         end
   endtask

   task automatic test_reset();
      @(negedge clk);
      check("R8", "done after reset", longint'(done), 0);
      check("R8", "col_rdy after reset", longint'(col_rdy), 1);
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++)
            check("R8", "sum after reset", entry(i, j), 0);
   endtask

   task automatic test_random();
      int lat;
      fill_random();
      pulse_clr();
      feed_block(0, lat);
      check("R4", "take-to-done edges", longint'(lat), 192);
      check_all("R1");
      check("R3", "col_rdy low at done", longint'(col_rdy), 0);
   endtask

   task automatic test_extreme();
      int lat;
      for (int n = 0; n < BLOCK; n++)
         for (int k = 0; k < DIM; k++) begin
            ta[n][k] = -32768;
            tb[n][k] = (k == 1) ? 32767 : -32768;
         end
      pulse_clr();
      feed_block(0, lat);
      check_all("R2");
      check("R2", "max positive sum", entry(0, 0), 64'sd68719476736);
      check("R2", "max negative sum", entry(2, 1), -64'sd68717379584);
   endtask

   task automatic test_gaps();
      int lat;
      fill_random();
      // one-hot a in the first column to exercise row mapping alone
      ta[0][0] = 0; ta[0][1] = 5; ta[0][2] = 0;
      pulse_clr();
      feed_block(2, lat);
      check_all("R7");
   endtask

   task automatic test_hold();
      longint snap [DIM][DIM];
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++) snap[i][j] = entry(i, j);
      @(negedge clk);
      col_a = '1; col_b = {3{16'h1234}}; col_vld = 1'b1;
      repeat (20) @(negedge clk);
      col_vld = 1'b0;
      check("R5", "done held", longint'(done), 1);
      check("R5", "col_rdy held low", longint'(col_rdy), 0);
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++)
            check("R5", "sum unchanged after done", entry(i, j), snap[i][j]);
   endtask

   task automatic test_clr_priority();
      int lat;
      fill_random();
      @(negedge clk);
      clr = 1'b1; col_vld = 1'b1; col_a = {3{16'h4000}}; col_b = {3{16'h4000}};
      @(negedge clk);
      clr = 1'b0; col_vld = 1'b0;
      check("R6", "done cleared", longint'(done), 0);
      check("R6", "col_rdy after clr", longint'(col_rdy), 1);
      check("R6", "sum zero after clr", entry(1, 1), 0);
      feed_block(0, lat);
      check("R6", "block length after clr+vld", longint'(lat), 192);
      check_all("R6");
   endtask

   task automatic test_clr_midblock();
      int lat;
      fill_random();
      pulse_clr();
      for (int n = 0; n < 10; n++) begin
         @(negedge clk);
         while (!col_rdy) @(negedge clk);
         col_a = {3{16'h7fff}}; col_b = {3{16'h7fff}}; col_vld = 1'b1;
      end
      @(negedge clk); col_vld = 1'b0;
      pulse_clr();
      feed_block(0, lat);
      check("R6", "restart length", longint'(lat), 192);
      check_all("R6");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_random();
      test_hold();
      test_extreme();
      test_gaps();
      test_clr_priority();
      test_clr_midblock();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule